// File: doc/BRIEF.md
# Polyphase Resampler Coefficient Store

This block supplies filter taps to a one-dimensional polyphase image resampler with 16 phases and up to 7 taps. Software loads packed coefficient words through a simple write port into four independent banks: vertical luma, horizontal luma, vertical chroma and horizontal chroma. Only phases 0 to 8 are kept. The other seven phases are produced on read by mirroring the stored half in phase and in tap order, which saves almost half of the storage.

A fixed-point source-position accumulator walks across a line. At the start of a line it loads a signed start offset, and for each output sample it adds an unsigned increment. The top bits of the position fraction select the phase. The coefficient set for that phase is looked up in the bank chosen by the reader, unpacked, sign-extended and registered. The integer part of the position tells the downstream multiply-accumulate which source sample sits at the centre of the filter.

Top module: `psc_coef_store`

## Requirements
- R1: After reset the position, the phase outputs and all coefficient outputs are zero, and every stored coefficient reads as zero.
- R2: A write whose `wr_ofs` has word select [7:6] = 0, 1 or 2 (words A, B, C) and phase [5:2] in 0..8 stores `wr_data[27:0]` for that bank and phase. Bits 31:28 of the data and offset bits [1:0] are ignored. The 84-bit string {A[27:0],B[27:0],C[27:0]} holds taps 0 to 6 as 12-bit fields from its most significant end, so tap t sits at bits [(6-t)*12 +: 12].
- R3: `coef_taps` and `coef_phase` are registered. They show the lookup for the `pos_phase`, `rd_bank` and `tap5_mode` that were present one cycle earlier.
- R4: For phase p in 9..15, output tap t equals stored tap 6-t of stored phase 16-p.
- R5: Phase 8 is read directly with no mirroring, and so are phases 0..7.
- R6: Writes with word select 3, or with a phase field of 9..15, change no stored value.
- R7: The four banks, selected by `wr_bank` and `rd_bank` (0..3), are independent.
- R8: Each 12-bit two's-complement coefficient, with unity gain at 1024, appears on `coef_taps` sign-extended to 16 bits. Tap t is at bits [t*16 +: 16].
- R9: With `tap5_mode` high, output taps 0 and 6 are zero for every phase, mirrored or not.
- R10: `line_start` loads the 24-bit position with the 19-bit `start_val` sign-extended. It takes precedence over `sample_step`.
- R11: `sample_step` without `line_start` adds the zero-extended 16-bit `inc_val`, which has 13 fraction bits. With neither input high the position holds. `pos_phase` is position bits [12:9] and `pos_int` is bits [23:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Coefficient word write strobe |
| wr_bank | input | 2 | Bank targeted by the write |
| wr_ofs | input | 8 | Byte offset within the bank: word select [7:6], phase [5:2] |
| wr_data | input | 32 | Packed coefficient word |
| rd_bank | input | 2 | Bank used for the lookup |
| tap5_mode | input | 1 | Force the outer taps to zero |
| line_start | input | 1 | Reload the position from the start value |
| sample_step | input | 1 | Advance the position by one increment |
| start_val | input | 19 | Signed start offset, 13 fraction bits |
| inc_val | input | 16 | Unsigned per-sample increment, 13 fraction bits |
| pos_int | output | 11 | Integer part of the position (signed) |
| pos_phase | output | 4 | Current phase index |
| coef_phase | output | 4 | Phase of the registered coefficient set |
| coef_taps | output | 112 | Seven sign-extended 16-bit taps |

## Verification
The bench builds the block with its default parameters: 4 banks, 16 phases, 7 taps of 12 bits widened to 16, and a 24-bit position with 13 fraction bits and a 19-bit start. These values expose every stored phase, the phase 8 boundary between direct and mirrored reads, and the ignored slots at phases 9 to 15 and word select 3. Because the start value is narrower than the position, a negative start must sign-extend correctly into the integer part. Long random runs of increments carry across the fraction boundary into that integer part.

// File: rtl/psc_pkg.sv
package psc_pkg;
   // word select field of the write offset
   typedef enum logic [1:0] {
      WSEL_A    = 2'd0,
      WSEL_B    = 2'd1,
      WSEL_C    = 2'd2,
      WSEL_NONE = 2'd3
   } psc_wsel_e;

   localparam int unsigned PSC_WORDS_PER_PHASE = 3;
endpackage

// File: rtl/psc_pos_accum.sv
module psc_pos_accum #(
   parameter int unsigned FRAC_W  = 13,
   parameter int unsigned INC_W   = 16,
   parameter int unsigned START_W = 19,
   parameter int unsigned POS_W   = 24,
   parameter int unsigned PH_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      line_start,
   input  logic                      sample_step,
   input  logic [START_W-1:0]        start_val,
   input  logic [INC_W-1:0]          inc_val,
   output logic [POS_W-FRAC_W-1:0]   pos_int,
   output logic [PH_W-1:0]           pos_phase
);
   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (line_start) begin
         pos_q <= {{(POS_W-START_W){start_val[START_W-1]}}, start_val};
      end else if (sample_step) begin
         pos_q <= pos_q + {{(POS_W-INC_W){1'b0}}, inc_val};
      end
   end

   assign pos_int   = pos_q[POS_W-1:FRAC_W];
   assign pos_phase = pos_q[FRAC_W-1 -: PH_W];
endmodule

// File: rtl/psc_bank_array.sv
module psc_bank_array #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned STORED_PH = 9,
   parameter int unsigned PH_W      = 4,
   parameter int unsigned WORD_W    = 28
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(NUM_BANKS)-1:0]  wr_bank,
   input  psc_pkg::psc_wsel_e            wr_sel,
   input  logic [PH_W-1:0]               wr_phase,
   input  logic [WORD_W-1:0]             wr_word,
   input  logic [$clog2(NUM_BANKS)-1:0]  rd_bank,
   input  logic [PH_W-1:0]               rd_phase,
   output logic [WORD_W-1:0]             word_a,
   output logic [WORD_W-1:0]             word_b,
   output logic [WORD_W-1:0]             word_c
);
   import psc_pkg::*;

   logic [WORD_W-1:0] mem_q [NUM_BANKS][STORED_PH][PSC_WORDS_PER_PHASE];
   logic              wr_hit;

   assign wr_hit = wr_en && (wr_sel != WSEL_NONE) && (int'(wr_phase) < STORED_PH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BANKS; b++)
            for (int p = 0; p < STORED_PH; p++)
               for (int w = 0; w < PSC_WORDS_PER_PHASE; w++)
                  mem_q[b][p][w] <= '0;
      end else if (wr_hit) begin
         mem_q[wr_bank][wr_phase][wr_sel] <= wr_word;
      end
   end

   assign word_a = mem_q[rd_bank][rd_phase][0];
   assign word_b = mem_q[rd_bank][rd_phase][1];
   assign word_c = mem_q[rd_bank][rd_phase][2];
endmodule

// File: rtl/psc_tap_unpack.sv
module psc_tap_unpack #(
   parameter int unsigned TAPS   = 7,
   parameter int unsigned COEF_W = 12,
   parameter int unsigned OUT_W  = 16,
   parameter int unsigned WORD_W = 28
) (
   input  logic [WORD_W-1:0]       word_a,
   input  logic [WORD_W-1:0]       word_b,
   input  logic [WORD_W-1:0]       word_c,
   output logic [TAPS*OUT_W-1:0]   taps_o
);
   logic [3*WORD_W-1:0] stream;
   assign stream = {word_a, word_b, word_c};

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [COEF_W-1:0] fld;
      assign fld = stream[(TAPS-1-t)*COEF_W +: COEF_W];
      assign taps_o[t*OUT_W +: OUT_W] = {{(OUT_W-COEF_W){fld[COEF_W-1]}}, fld};
   end
endmodule

// File: rtl/psc_coef_store.sv
module psc_coef_store #(
   parameter int unsigned NUM_BANKS  = 4,
   parameter int unsigned NUM_PHASES = 16,
   parameter int unsigned TAPS       = 7,
   parameter int unsigned COEF_W     = 12,
   parameter int unsigned OUT_W      = 16,
   parameter int unsigned FRAC_W     = 13,
   parameter int unsigned INC_W      = 16,
   parameter int unsigned START_W    = 19,
   parameter int unsigned POS_W      = 24,
   parameter int unsigned OFS_W      = 8,
   parameter int unsigned DATA_W     = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(NUM_BANKS)-1:0]  wr_bank,
   input  logic [OFS_W-1:0]              wr_ofs,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [$clog2(NUM_BANKS)-1:0]  rd_bank,
   input  logic                          tap5_mode,
   input  logic                          line_start,
   input  logic                          sample_step,
   input  logic [START_W-1:0]            start_val,
   input  logic [INC_W-1:0]              inc_val,
   output logic [POS_W-FRAC_W-1:0]       pos_int,
   output logic [$clog2(NUM_PHASES)-1:0] pos_phase,
   output logic [$clog2(NUM_PHASES)-1:0] coef_phase,
   output logic [TAPS*OUT_W-1:0]         coef_taps
);
   import psc_pkg::*;

   localparam int unsigned PH_W      = $clog2(NUM_PHASES);
   localparam int unsigned HALF      = NUM_PHASES / 2;
   localparam int unsigned STORED_PH = HALF + 1;
   localparam int unsigned WORD_W    = (TAPS * COEF_W) / PSC_WORDS_PER_PHASE;

   // elaboration-time parameter checks
   if (NUM_PHASES != (1 << PH_W) || NUM_PHASES < 4)
      $error("NUM_PHASES must be a power of two of at least 4");
   if ((TAPS % 2) == 0 || TAPS < 3)
      $error("TAPS must be odd and at least 3");
   if (((TAPS * COEF_W) % PSC_WORDS_PER_PHASE) != 0 || WORD_W > DATA_W)
      $error("taps must pack evenly into three data words");
   if (OUT_W <= COEF_W)
      $error("OUT_W must exceed COEF_W");
   if (FRAC_W < PH_W || POS_W <= START_W || POS_W <= INC_W || POS_W <= FRAC_W)
      $error("position widths inconsistent");
   if (OFS_W != PH_W + 4)
      $error("OFS_W must hold word select, phase and byte lanes");

   // write offset decode
   psc_wsel_e         wr_sel;
   logic [PH_W-1:0]   wr_phase;
   logic              unused_bits;
   assign wr_sel      = psc_wsel_e'(wr_ofs[OFS_W-1 -: 2]);
   assign wr_phase    = wr_ofs[PH_W+1:2];
   assign unused_bits = ^{wr_ofs[1:0], wr_data[DATA_W-1:WORD_W]};

   psc_pos_accum #(
      .FRAC_W(FRAC_W), .INC_W(INC_W), .START_W(START_W), .POS_W(POS_W), .PH_W(PH_W)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .sample_step(sample_step),
      .start_val(start_val), .inc_val(inc_val), .pos_int(pos_int), .pos_phase(pos_phase)
   );

   // mirror phases past the midpoint onto the stored half
   logic            mirror;
   logic [PH_W-1:0] rd_phase;
   assign mirror   = pos_phase > PH_W'(HALF);
   assign rd_phase = mirror ? (~pos_phase + PH_W'(1)) : pos_phase;

   logic [WORD_W-1:0] word_a, word_b, word_c;

   psc_bank_array #(
      .NUM_BANKS(NUM_BANKS), .STORED_PH(STORED_PH), .PH_W(PH_W), .WORD_W(WORD_W)
   ) u_banks (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_sel(wr_sel),
      .wr_phase(wr_phase), .wr_word(wr_data[WORD_W-1:0]), .rd_bank(rd_bank),
      .rd_phase(rd_phase), .word_a(word_a), .word_b(word_b), .word_c(word_c)
   );

   logic [TAPS*OUT_W-1:0] raw_taps, sel_taps;

   psc_tap_unpack #(
      .TAPS(TAPS), .COEF_W(COEF_W), .OUT_W(OUT_W), .WORD_W(WORD_W)
   ) u_unpack (
      .word_a(word_a), .word_b(word_b), .word_c(word_c), .taps_o(raw_taps)
   );

   for (genvar t = 0; t < TAPS; t++) begin : g_order
      localparam bit OUTER = (t == 0) || (t == TAPS - 1);
      always_comb begin
         if (OUTER && tap5_mode)
            sel_taps[t*OUT_W +: OUT_W] = '0;
         else if (mirror)
            sel_taps[t*OUT_W +: OUT_W] = raw_taps[(TAPS-1-t)*OUT_W +: OUT_W];
         else
            sel_taps[t*OUT_W +: OUT_W] = raw_taps[t*OUT_W +: OUT_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_taps  <= '0;
         coef_phase <= '0;
      end else begin
         coef_taps  <= sel_taps;
         coef_phase <= pos_phase;
      end
   end
endmodule

// File: rtl/psc_coef_store_chk.sv
module psc_coef_store_chk #(
   parameter int unsigned TAPS    = 7,
   parameter int unsigned COEF_W  = 12,
   parameter int unsigned OUT_W   = 16,
   parameter int unsigned FRAC_W  = 13,
   parameter int unsigned START_W = 19,
   parameter int unsigned POS_W   = 24,
   parameter int unsigned PH_W    = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tap5_mode,
   input logic                    line_start,
   input logic                    sample_step,
   input logic [START_W-1:0]      start_val,
   input logic [POS_W-FRAC_W-1:0] pos_int,
   input logic [PH_W-1:0]         pos_phase,
   input logic [PH_W-1:0]         coef_phase,
   input logic [TAPS*OUT_W-1:0]   coef_taps
);
   AST_COEF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> coef_phase == $past(pos_phase)); // R3

   AST_OUTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tap5_mode |=> (coef_taps[0 +: OUT_W] == '0) && (coef_taps[(TAPS-1)*OUT_W +: OUT_W] == '0)); // R9

   AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> ($signed(pos_int) == $signed($past(start_val[START_W-1:FRAC_W])))
                     && (pos_phase == $past(start_val[FRAC_W-1 -: PH_W]))); // R10

   AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && !sample_step) |=> $stable(pos_int) && $stable(pos_phase)); // R11

   for (genvar t = 0; t < TAPS; t++) begin : g_sx
      AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(coef_taps[t*OUT_W+COEF_W-1 +: OUT_W-COEF_W+1]) == 0) ||
         ($countones(coef_taps[t*OUT_W+COEF_W-1 +: OUT_W-COEF_W+1]) == OUT_W-COEF_W+1)); // R8
   end
endmodule

bind psc_coef_store psc_coef_store_chk #(
   .TAPS(TAPS), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W),
   .START_W(START_W), .POS_W(POS_W), .PH_W($clog2(NUM_PHASES))
) u_chk (
   .clk(clk), .rst_n(rst_n), .tap5_mode(tap5_mode), .line_start(line_start),
   .sample_step(sample_step), .start_val(start_val), .pos_int(pos_int),
   .pos_phase(pos_phase), .coef_phase(coef_phase), .coef_taps(coef_taps)
);

// File: tb/tb_psc_coef_store.sv
`timescale 1ns/1ps
module tb_psc_coef_store;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_bank = '0;
   logic [7:0]   wr_ofs = '0;
   logic [31:0]  wr_data = '0;
   logic [1:0]   rd_bank = '0;
   logic         tap5_mode = 1'b0;
   logic         line_start = 1'b0;
   logic         sample_step = 1'b0;
   logic [18:0]  start_val = '0;
   logic [15:0]  inc_val = '0;
   logic [10:0]  pos_int;
   logic [3:0]   pos_phase;
   logic [3:0]   coef_phase;
   logic [111:0] coef_taps;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] mw [4][9][3];
   logic [23:0] mpos;

   always #2 clk = ~clk;

   psc_coef_store dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_ofs(wr_ofs),
      .wr_data(wr_data), .rd_bank(rd_bank), .tap5_mode(tap5_mode),
      .line_start(line_start), .sample_step(sample_step), .start_val(start_val),
      .inc_val(inc_val), .pos_int(pos_int), .pos_phase(pos_phase),
      .coef_phase(coef_phase), .coef_taps(coef_taps)
   );

   function automatic logic [15:0] exp_tap(int b, int p, int t, bit five);
      int sp, st;
      logic [83:0] s;
      logic [11:0] f;
      if (five && (t == 0 || t == 6)) return 16'h0;
      sp = (p <= 8) ? p : 16 - p;       // R4 / R5
      st = (p <= 8) ? t : 6 - t;
      s = {mw[b][sp][0][27:0], mw[b][sp][1][27:0], mw[b][sp][2][27:0]};
      f = s[(6-st)*12 +: 12];
      return {{4{f[11]}}, f};           // R8
   endfunction

   function automatic logic [111:0] exp_set(int b, int p, bit five);
      logic [111:0] v;
      for (int t = 0; t < 7; t++) v[t*16 +: 16] = exp_tap(b, p, t, five);
      return v;
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int b, logic [7:0] ofs, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = 2'(b); wr_ofs = ofs; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (ofs[7:6] != 2'd3 && ofs[5:2] <= 4'd8) mw[b][ofs[5:2]][ofs[7:6]] = d;  // R2 / R6
   endtask

   task automatic wr_phase(int b, int p, logic [11:0] tp [7]);
      logic [83:0] s;
      for (int t = 0; t < 7; t++) s[(6-t)*12 +: 12] = tp[t];
      wr(b, {2'd0, 4'(p), 2'(b)}, {4'($urandom), s[83:56]});
      wr(b, {2'd1, 4'(p), 2'd0}, {4'($urandom), s[55:28]});
      wr(b, {2'd2, 4'(p), 2'd3}, {4'($urandom), s[27:0]});
   endtask

   task automatic read_check(int b, int p, bit five, string req);
      logic [3:0] prev;
      @(negedge clk);
      prev = pos_phase;
      rd_bank = 2'(b); tap5_mode = five;
      line_start = 1'b1; start_val = {6'd0, 4'(p), 9'd0};
      @(negedge clk);
      line_start = 1'b0;
      mpos = {11'd0, 4'(p), 9'd0};
      chk("R3 coef_phase lags pos_phase", {124'd0, coef_phase}, {124'd0, prev});
      chk("R11 phase from start", {124'd0, pos_phase}, {124'd0, 4'(p)});
      @(negedge clk);
      chk("R3 coef_phase", {124'd0, coef_phase}, {124'd0, 4'(p)});
      chk(req, {16'd0, coef_taps}, {16'd0, exp_set(b, p, five)});
   endtask

   task automatic check_pos(string req);
      chk(req, {113'd0, pos_int, pos_phase}, {113'd0, mpos[23:13], mpos[12:9]});
   endtask

   initial begin
      logic [11:0] tp [7];
      void'($urandom(32'd1234));
      for (int b = 0; b < 4; b++)
         for (int p = 0; p < 9; p++)
            for (int w = 0; w < 3; w++) mw[b][p][w] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pos", {113'd0, pos_int, pos_phase}, 128'd0);
      chk("R1 coef", {12'd0, coef_phase, coef_taps}, 128'd0);
      read_check(2, 5, 1'b0, "R1 empty store");

      // R2 / R8 directed packing with sign extremes
      tp = '{12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h123, 12'hABC, 12'h400};
      wr_phase(1, 3, tp);
      read_check(1, 3, 1'b0, "R2 packing");
      chk("R8 negative tap2", {112'd0, coef_taps[2*16 +: 16]}, {112'd0, 16'hF800});
      chk("R8 unity tap6", {112'd0, coef_taps[6*16 +: 16]}, {112'd0, 16'h0400});

      // R4 / R5 mirrored and direct phases
      for (int p = 0; p <= 8; p++) begin
         for (int t = 0; t < 7; t++) tp[t] = 12'($urandom);
         wr_phase(2, p, tp);
      end
      for (int p = 9; p < 16; p++) read_check(2, p, 1'b0, "R4 mirror");
      read_check(2, 8, 1'b0, "R5 phase 8 direct");
      read_check(2, 7, 1'b0, "R5 phase 7 direct");
      read_check(2, 0, 1'b0, "R5 phase 0 direct");

      // R6 ignored slots
      wr(2, {2'd0, 4'd12, 2'd0}, 32'hFFFF_FFFF);
      wr(2, {2'd3, 4'd2, 2'd0}, 32'h0FFF_FFFF);
      read_check(2, 4, 1'b0, "R6 phase slot 12 ignored");
      read_check(2, 12, 1'b0, "R6 mirror after ignored write");
      read_check(2, 2, 1'b0, "R6 word select 3 ignored");

      // R7 bank independence
      tp = '{12'h111, 12'h222, 12'h333, 12'h444, 12'h555, 12'h666, 12'h777};
      wr_phase(0, 6, tp);
      tp = '{12'h999, 12'h888, 12'h777, 12'h666, 12'h555, 12'h444, 12'h333};
      wr_phase(3, 6, tp);
      read_check(0, 6, 1'b0, "R7 bank 0");
      read_check(3, 6, 1'b0, "R7 bank 3");
      read_check(1, 6, 1'b0, "R7 bank 1 untouched");

      // R9 five-tap mode, direct and mirrored
      read_check(2, 3, 1'b1, "R9 five-tap direct");
      read_check(2, 13, 1'b1, "R9 five-tap mirrored");
      read_check(0, 10, 1'b1, "R9 five-tap bank 0");

      // R10 / R11 position accumulator
      @(negedge clk);
      start_val = 19'h7EDCB; line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      mpos = {{5{1'b1}}, 19'h7EDCB};
      check_pos("R10 negative start");
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         inc_val = 16'($urandom);
         sample_step = 1'b1;
         @(negedge clk);
         sample_step = 1'b0;
         mpos = mpos + {8'd0, inc_val};
         check_pos("R11 step");
      end
      @(negedge clk);
      check_pos("R11 hold");
      start_val = 19'h0_5A00; line_start = 1'b1; sample_step = 1'b1; inc_val = 16'hFFFF;
      @(negedge clk);
      line_start = 1'b0; sample_step = 1'b0;
      mpos = {5'd0, 19'h0_5A00};
      check_pos("R10 start beats step");

      // random mix of writes and lookups
      for (int i = 0; i < 300; i++) begin
         wr(int'($urandom_range(0, 3)), 8'($urandom), $urandom);
         if ((i % 4) == 0)
            read_check(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                       1'($urandom), "R2 R4 R7 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule